// File: doc/BRIEF.md
# Codec Channel Control Register File

This block holds the configuration of one channel of a multi-channel voice codec. The host reaches it through byte-wide reads and writes on an 8-bit address. It keeps 56 balance-filter coefficient bytes in two separate windows. It also keeps a channel enable, the receive bit offset and time slot, two 11-bit receive gain words and a 31-bit termination coefficient. Every stored field drives an output port, where the datapath (not part of this block) picks it up. Registers wider than a byte are laid out little-endian over consecutive addresses.

A reset-control byte gives software two kinds of reset:
- **Defaults reload.** Setting bit 0 puts every other register back to its default value at once. Most defaults are zero, but a few addresses have fixed non-zero values.
- **Datapath reset.** Setting bit 1 raises a reset line to the datapath and leaves the stored configuration alone.

The reset-control byte keeps its value until the next frame-sync pulse, and then it clears. After a defaults reload, a busy output stays high for a fixed quiet time of 256 µs, counted in clock cycles from a clock-frequency parameter. The block drops any host write that arrives while busy is high. A synchronous active-low hardware reset restores the registers and also holds the datapath reset.

Top module: `codec_ctrl_regs`

## Requirements
- R1: Balance bytes sit at 0x00–0x1B and 0x40–0x5B, each read and written as a full byte. All of them default to 0x00 except 0x03 and 0x05, which default to 0x80, and 0x45, which defaults to 0x88. `bal_coef_o` byte k (bits 8k+7:8k) holds the k-th byte of 0x00–0x1B followed by 0x40–0x5B.
- R2: The configuration registers are as follows. The channel enable is 0x81 bit 0 and defaults to 0. The receive bit offset is 0x82 bits 2:0 and defaults to 0. The receive slot is 0x83 and defaults to 16×CHAN_INDEX. Gain 1 is at 0x84 (low byte) and 0x85 and defaults to 0x0400. Gain 2 is at 0x86/0x87 and defaults to 0x01AC. The termination coefficient is at 0x8C (lowest byte) through 0x8F and defaults to 0x07ED0000. Each field appears on its output port.
- R3: Bits above a field's width are dropped on write and read as 0. This covers 0x80 bits 7:2, 0x81 bits 7:1, 0x82 bits 7:3, 0x85 and 0x87 bits 7:3, and 0x8F bit 7.
- R4: Reads of unmapped addresses, for example 0x1C, 0x88 and 0xFF, return 0x00. Writes to unmapped addresses change no register.
- R5: A write to 0x80 with bit 0 set returns every register except 0x80 to its default on that same clock edge.
- R6: 0x80 keeps the value written to it until the first frame_sync pulse after the write, and then it reads 0x00. A frame_sync pulse on the same cycle as the write does not clear it.
- R7: state_rst_o is high whenever 0x80 bit 1 is set or rst_n is low. Setting bit 1 alone changes no other register.
- R8: busy_o rises on the cycle after a write that sets 0x80 bit 0 and stays high for exactly QUIET_US×CLK_HZ/10⁶ cycles. Every host write made while busy_o is high is dropped.
- R9: A hardware reset (rst_n low at a clock edge) restores all defaults, clears 0x80 and lowers busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| host_addr | input | 8 | Host byte address |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| frame_sync | input | 1 | One-cycle pulse at each PCM frame start |
| busy_o | output | 1 | Quiet time after a defaults reload |
| state_rst_o | output | 1 | Datapath state reset |
| bal_coef_o | output | 16×BAL_SPAN (448) | Balance coefficient bytes |
| chan_active_o | output | 1 | Channel enable |
| rx_bit_off_o | output | 3 | Receive bit offset |
| rx_slot_o | output | 8 | Receive time slot |
| rx_gain1_o | output | 11 | Receive gain 1 |
| rx_gain2_o | output | 11 | Receive gain 2 |
| term_coef_o | output | 31 | Termination coefficient |

## Verification
A wrong default shows up on the field's output port and in a host read on the first cycle after reset or after a defaults reload, so defaults are checked at both points. A reset-control byte that is stuck or clears too early shows up in a 0x80 read, and on state_rst_o, within one frame_sync pulse. A quiet-time counter that is off by even one cycle moves the falling edge of busy_o, so the bench counts the exact length of busy_o. A write path that ignores busy shows up as a changed readback of the register that was written.

// File: rtl/codec_ctrl_pkg.sv
// Package codec_ctrl_pkg
// Holds the address map, the default values and the helper functions shared by
// the control register file. Assumes the balance windows do not overlap 0x80-0x8F.
package codec_ctrl_pkg;

    localparam logic [7:0] BAL_BASE_A    = 8'h00;
    localparam logic [7:0] BAL_BASE_B    = 8'h40;

    localparam logic [7:0] ADDR_RESET    = 8'h80;
    localparam logic [7:0] ADDR_ACTIVE   = 8'h81;
    localparam logic [7:0] ADDR_BITOFF   = 8'h82;
    localparam logic [7:0] ADDR_SLOT     = 8'h83;
    localparam logic [7:0] ADDR_GAIN1_LO = 8'h84;
    localparam logic [7:0] ADDR_GAIN1_HI = 8'h85;
    localparam logic [7:0] ADDR_GAIN2_LO = 8'h86;
    localparam logic [7:0] ADDR_GAIN2_HI = 8'h87;
    localparam logic [7:0] ADDR_TERM_B0  = 8'h8C;
    localparam logic [7:0] ADDR_TERM_B1  = 8'h8D;
    localparam logic [7:0] ADDR_TERM_B2  = 8'h8E;
    localparam logic [7:0] ADDR_TERM_B3  = 8'h8F;

    localparam int GAIN_W = 11;
    localparam int TERM_W = 31;

    localparam logic [GAIN_W-1:0] GAIN1_DFLT = 11'h400;
    localparam logic [GAIN_W-1:0] GAIN2_DFLT = 11'h1AC;
    localparam logic [TERM_W-1:0] TERM_DFLT  = 31'h07ED_0000;

    // Address of the i-th balance byte: first window, then second window.
    function automatic logic [7:0] bal_addr(input int i, input int span);
        logic [7:0] a;
        if (i < span) a = BAL_BASE_A + 8'(i);
        else          a = BAL_BASE_B + 8'(i - span);
        return a;
    endfunction

    // Irregular default of a balance byte, selected by its address.
    function automatic logic [7:0] bal_dflt(input logic [7:0] a);
        logic [7:0] d;
        case (a)
            8'h03, 8'h05: d = 8'h80;
            8'h45:        d = 8'h88;
            default:      d = 8'h00;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/codec_bal_bank.sv
// Module codec_bal_bank
// Stores the balance-filter coefficient bytes of both address windows. Each
// byte loads its own default on hardware reset or on a defaults reload.
// Assumes wr_en is already gated by the caller's busy logic.
module codec_bal_bank
    import codec_ctrl_pkg::*;
#(
    parameter int BAL_SPAN = 28
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_dflt,
    input  logic                      wr_en,
    input  logic [7:0]                addr,
    input  logic [7:0]                wdata,
    output logic [7:0]                rdata,
    output logic [2*BAL_SPAN*8-1:0]   coef_o
);

    localparam int BYTES = 2 * BAL_SPAN;

    // Packed default image of the whole bank, used by the reload check.
    function automatic logic [BYTES*8-1:0] dflt_image();
        logic [BYTES*8-1:0] v;
        v = '0;
        for (int i = 0; i < BYTES; i++) v[i*8 +: 8] = bal_dflt(bal_addr(i, BAL_SPAN));
        return v;
    endfunction

    localparam logic [BYTES*8-1:0] DFLT_IMAGE = dflt_image();

    logic [7:0] coef_q [BYTES];

    for (genvar gi = 0; gi < BYTES; gi++) begin : g_byte
        localparam logic [7:0] MY_ADDR = bal_addr(gi, BAL_SPAN);
        localparam logic [7:0] MY_DFLT = bal_dflt(MY_ADDR);

        // Byte storage: default on reset or reload, else host write.
        always_ff @(posedge clk) begin
            if (!rst_n || load_dflt) coef_q[gi] <= MY_DFLT;
            else if (wr_en && addr == MY_ADDR) coef_q[gi] <= wdata;
        end

        assign coef_o[gi*8 +: 8] = coef_q[gi];
    end

    // Read mux: selected byte, or zero when the address is outside the bank.
    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < BYTES; i++) begin
            if (addr == bal_addr(i, BAL_SPAN)) rdata = coef_q[i];
        end
    end

    // R5: a reload leaves the whole bank at its default image.
    p_bank_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_dflt |=> (coef_o == DFLT_IMAGE));

    // R8: with no write and no reload, the bank holds its contents.
    p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !load_dflt) |=> $stable(coef_o));

endmodule

// File: rtl/codec_cfg_regs.sv
// Module codec_cfg_regs
// Holds the per-channel configuration fields (enable, bit offset, slot, two
// gain words, termination coefficient). Multi-byte fields are little-endian;
// bits above a field's width are dropped on write and read as zero.
module codec_cfg_regs
    import codec_ctrl_pkg::*;
#(
    parameter int CHAN_INDEX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_dflt,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              active_o,
    output logic [2:0]        bit_off_o,
    output logic [7:0]        slot_o,
    output logic [GAIN_W-1:0] gain1_o,
    output logic [GAIN_W-1:0] gain2_o,
    output logic [TERM_W-1:0] term_o
);

    localparam logic [7:0] SLOT_DFLT = 8'(16 * CHAN_INDEX);

    // Field storage: defaults on reset or reload, byte writes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || load_dflt) begin
            active_o  <= 1'b0;
            bit_off_o <= 3'd0;
            slot_o    <= SLOT_DFLT;
            gain1_o   <= GAIN1_DFLT;
            gain2_o   <= GAIN2_DFLT;
            term_o    <= TERM_DFLT;
        end else if (wr_en) begin
            case (addr)
                ADDR_ACTIVE:   active_o       <= wdata[0];
                ADDR_BITOFF:   bit_off_o      <= wdata[2:0];
                ADDR_SLOT:     slot_o         <= wdata;
                ADDR_GAIN1_LO: gain1_o[7:0]   <= wdata;
                ADDR_GAIN1_HI: gain1_o[10:8]  <= wdata[2:0];
                ADDR_GAIN2_LO: gain2_o[7:0]   <= wdata;
                ADDR_GAIN2_HI: gain2_o[10:8]  <= wdata[2:0];
                ADDR_TERM_B0:  term_o[7:0]    <= wdata;
                ADDR_TERM_B1:  term_o[15:8]   <= wdata;
                ADDR_TERM_B2:  term_o[23:16]  <= wdata;
                ADDR_TERM_B3:  term_o[30:24]  <= wdata[6:0];
                default: ;
            endcase
        end
    end

    // Read mux: zero-extended field bytes, zero for any other address.
    always_comb begin
        case (addr)
            ADDR_ACTIVE:   rdata = {7'd0, active_o};
            ADDR_BITOFF:   rdata = {5'd0, bit_off_o};
            ADDR_SLOT:     rdata = slot_o;
            ADDR_GAIN1_LO: rdata = gain1_o[7:0];
            ADDR_GAIN1_HI: rdata = {5'd0, gain1_o[10:8]};
            ADDR_GAIN2_LO: rdata = gain2_o[7:0];
            ADDR_GAIN2_HI: rdata = {5'd0, gain2_o[10:8]};
            ADDR_TERM_B0:  rdata = term_o[7:0];
            ADDR_TERM_B1:  rdata = term_o[15:8];
            ADDR_TERM_B2:  rdata = term_o[23:16];
            ADDR_TERM_B3:  rdata = {1'b0, term_o[30:24]};
            default:       rdata = 8'h00;
        endcase
    end

    // R5: a reload puts the gain and termination fields at their defaults.
    p_cfg_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_dflt |=> (gain1_o == GAIN1_DFLT && gain2_o == GAIN2_DFLT
                       && term_o == TERM_DFLT && !active_o));

    // R8: with no write and no reload, every field holds.
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !load_dflt) |=> $stable({active_o, bit_off_o, slot_o,
                                            gain1_o, gain2_o, term_o}));

endmodule

// File: rtl/codec_rst_seq.sv
// Module codec_rst_seq
// Holds the two reset-control bits, clears them on the first frame pulse
// after they are written, and times the post-reload quiet window.
// Assumes bits_wr is a single accepted write to the reset-control address.
module codec_rst_seq #(
    parameter int QUIET_CYC = 12800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bits_wr,
    input  logic [1:0] wbits,
    input  logic       frame_sync,
    output logic [1:0] bits_q,
    output logic       busy_o
);

    localparam int CNT_W = $clog2(QUIET_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(QUIET_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Control bits: written value held until the next frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          bits_q <= 2'b00;
        else if (bits_wr)    bits_q <= wbits;
        else if (frame_sync) bits_q <= 2'b00;
    end

    // Quiet-time counter: busy for exactly QUIET_CYC cycles after a reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (bits_wr && wbits[0]) begin
            busy_o <= 1'b1;
            cnt_q  <= CNT_LOAD;
        end else if (busy_o) begin
            if (cnt_q == '0) busy_o <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // R8: a reload request raises busy on the next cycle.
    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bits_wr && wbits[0]) |=> busy_o);

    // R8: busy cannot end while the quiet counter is still running.
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q != '0 && !bits_wr) |=> busy_o);

    // R6: a frame pulse with no write clears the control bits.
    p_frame_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && !bits_wr) |=> (bits_q == 2'b00));

endmodule

// File: rtl/codec_ctrl_regs.sv
// Module codec_ctrl_regs
// Top of the codec channel control register file. Gates host writes with the
// busy flag, decodes the reset-control byte and merges the read data of the
// sub-blocks. Assumes a one-byte-per-cycle host and a one-cycle frame pulse.
module codec_ctrl_regs
    import codec_ctrl_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int QUIET_US   = 256,
    parameter int CHAN_INDEX = 1,
    parameter int BAL_SPAN   = 28
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               host_addr,
    input  logic                     host_wr,
    input  logic [7:0]               host_wdata,
    output logic [7:0]               host_rdata,
    input  logic                     frame_sync,
    output logic                     busy_o,
    output logic                     state_rst_o,
    output logic [2*BAL_SPAN*8-1:0]  bal_coef_o,
    output logic                     chan_active_o,
    output logic [2:0]               rx_bit_off_o,
    output logic [7:0]               rx_slot_o,
    output logic [GAIN_W-1:0]        rx_gain1_o,
    output logic [GAIN_W-1:0]        rx_gain2_o,
    output logic [TERM_W-1:0]        term_coef_o
);

    localparam int QUIET_CYC = (CLK_HZ / 1_000_000) * QUIET_US;

    logic       wr_ok;
    logic       ctl_wr;
    logic       load_dflt;
    logic [1:0] ctl_bits;
    logic [7:0] bank_rd;
    logic [7:0] cfg_rd;

    // Write acceptance and reset-control decode.
    assign wr_ok     = host_wr && !busy_o;
    assign ctl_wr    = wr_ok && (host_addr == ADDR_RESET);
    assign load_dflt = ctl_wr && host_wdata[0];

    // Datapath reset follows control bit 1 and the hardware reset.
    assign state_rst_o = ctl_bits[1] || !rst_n;

    codec_rst_seq #(.QUIET_CYC(QUIET_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bits_wr    (ctl_wr),
        .wbits      (host_wdata[1:0]),
        .frame_sync (frame_sync),
        .bits_q     (ctl_bits),
        .busy_o     (busy_o)
    );

    codec_bal_bank #(.BAL_SPAN(BAL_SPAN)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_dflt (load_dflt),
        .wr_en     (wr_ok),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .rdata     (bank_rd),
        .coef_o    (bal_coef_o)
    );

    codec_cfg_regs #(.CHAN_INDEX(CHAN_INDEX)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_dflt (load_dflt),
        .wr_en     (wr_ok),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .rdata     (cfg_rd),
        .active_o  (chan_active_o),
        .bit_off_o (rx_bit_off_o),
        .slot_o    (rx_slot_o),
        .gain1_o   (rx_gain1_o),
        .gain2_o   (rx_gain2_o),
        .term_o    (term_coef_o)
    );

    // Read merge: each source returns zero outside its own addresses.
    always_comb begin
        host_rdata = bank_rd | cfg_rd;
        if (host_addr == ADDR_RESET) host_rdata = {6'd0, ctl_bits};
    end

    // R7: setting control bit 1 raises the datapath reset on the next cycle.
    p_state_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && host_wdata[1]) |=> state_rst_o);

    // R8: a write seen while busy leaves the control byte unchanged.
    p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && host_wr && !frame_sync) |=> $stable(ctl_bits));

endmodule

// File: tb/codec_ctrl_regs_test.sv
// Directed bench for codec_ctrl_regs: one task per scenario.
module codec_ctrl_regs_test;

    localparam int QUIET = 50 * 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   host_addr = 8'h00;
    logic         host_wr = 1'b0;
    logic [7:0]   host_wdata = 8'h00;
    logic [7:0]   host_rdata;
    logic         frame_sync = 1'b0;
    logic         busy_o;
    logic         state_rst_o;
    logic [447:0] bal_coef_o;
    logic         chan_active_o;
    logic [2:0]   rx_bit_off_o;
    logic [7:0]   rx_slot_o;
    logic [10:0]  rx_gain1_o;
    logic [10:0]  rx_gain2_o;
    logic [30:0]  term_coef_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    codec_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .frame_sync(frame_sync),
        .busy_o(busy_o), .state_rst_o(state_rst_o), .bal_coef_o(bal_coef_o),
        .chan_active_o(chan_active_o), .rx_bit_off_o(rx_bit_off_o),
        .rx_slot_o(rx_slot_o), .rx_gain1_o(rx_gain1_o), .rx_gain2_o(rx_gain2_o),
        .term_coef_o(term_coef_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [7:0] exp);
        host_addr = a;
        #1;
        check(tag, host_rdata, exp);
    endtask

    task automatic frame_pulse();
        @(negedge clk);
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R7 state_rst during hw reset", state_rst_o, 1);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_defaults(input string tag);
        rd_check({tag, " R1 bal 0x00"}, 8'h00, 8'h00);
        rd_check({tag, " R1 bal 0x03"}, 8'h03, 8'h80);
        rd_check({tag, " R1 bal 0x05"}, 8'h05, 8'h80);
        rd_check({tag, " R1 bal 0x45"}, 8'h45, 8'h88);
        check({tag, " R1 bal_coef byte 33"}, bal_coef_o[33*8 +: 8], 8'h88);
        rd_check({tag, " R2 slot"}, 8'h83, 8'h10);
        rd_check({tag, " R2 gain1 hi"}, 8'h85, 8'h04);
        rd_check({tag, " R2 gain2 lo"}, 8'h86, 8'hAC);
        rd_check({tag, " R2 term b2"}, 8'h8E, 8'hED);
        rd_check({tag, " R2 term b3"}, 8'h8F, 8'h07);
        check({tag, " R2 gain1 port"}, rx_gain1_o, 11'h400);
        check({tag, " R2 gain2 port"}, rx_gain2_o, 11'h1AC);
        check({tag, " R2 term port"}, term_coef_o, 31'h07ED0000);
        check({tag, " R2 active port"}, chan_active_o, 0);
        check({tag, " R2 bitoff port"}, rx_bit_off_o, 0);
    endtask

    task automatic t_after_hw_reset();
        t_defaults("R9");
        rd_check("R9 ctl byte", 8'h80, 8'h00);
        check("R9 busy", busy_o, 0);
        check("R7 state_rst idle", state_rst_o, 0);
    endtask

    task automatic t_read_write();
        wr(8'h10, 8'h5A);
        wr(8'h5B, 8'hC3);
        rd_check("R1 bal 0x10 rw", 8'h10, 8'h5A);
        rd_check("R1 bal 0x5B rw", 8'h5B, 8'hC3);
        check("R1 bal_coef byte 55", bal_coef_o[55*8 +: 8], 8'hC3);
        wr(8'h84, 8'hFF);
        wr(8'h85, 8'hFF);
        rd_check("R3 gain1 hi masked", 8'h85, 8'h07);
        check("R3 gain1 port", rx_gain1_o, 11'h7FF);
        wr(8'h8F, 8'hFF);
        rd_check("R3 term b3 masked", 8'h8F, 8'h7F);
        wr(8'h81, 8'hFF);
        rd_check("R3 active masked", 8'h81, 8'h01);
        wr(8'h82, 8'hFD);
        rd_check("R3 bitoff masked", 8'h82, 8'h05);
        check("R2 bitoff port", rx_bit_off_o, 5);
        wr(8'h83, 8'h3C);
        check("R2 slot port", rx_slot_o, 8'h3C);
    endtask

    task automatic t_unmapped();
        wr(8'h1C, 8'h55);
        wr(8'h88, 8'h55);
        wr(8'h3F, 8'h55);
        rd_check("R4 read 0x1C", 8'h1C, 8'h00);
        rd_check("R4 read 0x88", 8'h88, 8'h00);
        rd_check("R4 read 0xFF", 8'hFF, 8'h00);
        rd_check("R4 neighbour 0x1B", 8'h1B, 8'h00);
        rd_check("R4 neighbour 0x40", 8'h40, 8'h00);
        check("R4 gain1 untouched", rx_gain1_o, 11'h7FF);
    endtask

    task automatic t_state_reset();
        wr(8'h80, 8'h02);
        check("R7 state_rst high", state_rst_o, 1);
        rd_check("R6 ctl byte held", 8'h80, 8'h02);
        check("R7 gain1 untouched", rx_gain1_o, 11'h7FF);
        rd_check("R7 bal 0x10 untouched", 8'h10, 8'h5A);
        check("R7 no busy", busy_o, 0);
        frame_pulse();
        rd_check("R6 ctl byte cleared", 8'h80, 8'h00);
        check("R7 state_rst low", state_rst_o, 0);
        // frame pulse on the write cycle must not clear
        @(negedge clk);
        host_addr = 8'h80; host_wdata = 8'h02; host_wr = 1'b1; frame_sync = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; frame_sync = 1'b0;
        rd_check("R6 same-cycle frame keeps", 8'h80, 8'h02);
        frame_pulse();
        rd_check("R6 next frame clears", 8'h80, 8'h00);
    endtask

    task automatic t_soft_reset();
        int n;
        wr(8'h80, 8'hFF);
        check("R8 busy after reload", busy_o, 1);
        rd_check("R3 ctl byte masked", 8'h80, 8'h03);
        rd_check("R5 bal 0x10 restored", 8'h10, 8'h00);
        rd_check("R5 bal 0x45 restored", 8'h45, 8'h88);
        check("R5 gain1 restored", rx_gain1_o, 11'h400);
        check("R5 active restored", chan_active_o, 0);
        check("R5 slot restored", rx_slot_o, 8'h10);
        wr(8'h81, 8'h01);
        check("R8 write dropped while busy", chan_active_o, 0);
        n = 2;
        while (busy_o && n < QUIET + 20) begin
            @(negedge clk);
            n++;
        end
        check("R8 busy length", n, QUIET);
        rd_check("R6 ctl held without frame", 8'h80, 8'h03);
        frame_pulse();
        rd_check("R6 ctl cleared by frame", 8'h80, 8'h00);
        wr(8'h81, 8'h01);
        check("R8 write accepted after busy", chan_active_o, 1);
    endtask

    task automatic t_hw_reset();
        wr(8'h86, 8'h11);
        wr(8'h03, 8'h00);
        wr(8'h80, 8'h02);
        hw_reset();
        t_after_hw_reset();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_after_hw_reset();
        t_read_write();
        t_unmapped();
        t_state_reset();
        t_soft_reset();
        t_hw_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule